// File: doc/BRIEF.md
# Nested Priority Interrupt Controller Core

This core takes up to eight interrupt request lines and decides which of them may interrupt the processor. It captures the requests into a register every clock and removes the masked ones. It then finds the most urgent remaining request and compares it with the most urgent level already being serviced, held in the in-service register (ISR). The interrupt output rises only when the new request is strictly more urgent than every level in service. The processor answers with a train of active-low acknowledge pulses. On the falling edge of the first pulse the core takes the winning level, sets its in-service bit and latches that level as the vector index. The index is shown with a valid strobe while the last pulse of the train is low. The last pulse is the second pulse in 86 mode and the third pulse in 85 mode.

In-service bits are cleared in three ways: by a non-specific end-of-interrupt (EOI) command, by a specific EOI command that names a level, or automatically on the rising edge of the last acknowledge pulse. Urgency is measured from a 3-bit lowest-priority pointer. After reset the pointer is 7, which gives fixed order 0 (most urgent) down to 7. In rotating operation the pointer moves to the level that was just serviced, so that level becomes the least urgent. Special mask mode lets masked in-service levels stop blocking other requests. It also keeps those levels out of the reach of a non-specific EOI.

The acknowledge tracker is a three-state machine. ACK_IDLE goes to ACK_LOW on a falling acknowledge edge; this is the first pulse, where the level is selected. ACK_LOW goes back to ACK_IDLE on the rising edge of the last pulse. On the rising edge of an earlier pulse, ACK_LOW goes to ACK_GAP and the pulse count advances. ACK_GAP goes to ACK_LOW on the next falling edge.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset the ISR and IMR are all zero, the pointer is 7, and int_o, vec_valid_o and vec_o are all zero.
- R2: An unmasked request present on req_i is captured at a clock edge. int_o is high after that edge when no in-service level blocks it.
- R3: A request whose IMR bit is 1 never raises int_o and is never chosen on acknowledge.
- R4: While an in-service bit counts for blocking, int_o is raised only by a request strictly more urgent than the most urgent counted in-service level. int_o is low during an acknowledge sequence.
- R5: At the first falling acknowledge edge, the most urgent unmasked, unblocked request has its in-service bit set and its level latched as vec_o.
- R6: vec_valid_o is high only while the last acknowledge pulse is low. This is pulse 2 when the 86-mode bit is 1 and pulse 3 when it is 0.
- R7: With automatic EOI enabled, the serviced in-service bit clears at the rising edge of the last acknowledge pulse.
- R8: EOI code 2'b00 (non-specific) clears the most urgent in-service bit that counts for blocking.
- R9: EOI code 2'b01 (specific) clears exactly the in-service bit named by eoi_lvl_i. Code 2'b11 has no effect.
- R10: With special mask mode on, in-service bits whose IMR bit is 1 neither block requests nor get cleared by a non-specific EOI.
- R11: EOI code 2'b10 clears the most urgent counted in-service bit and moves the pointer to that level. With automatic EOI and automatic rotation enabled, the pointer moves to the serviced level at the last rising edge.
- R12: If no request can be granted at the first falling edge, vec_o becomes 7 and no in-service bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Interrupt request lines, bit n is level n |
| int_o | output | 1 | Interrupt to the processor |
| ack_n_i | input | 1 | Active-low acknowledge pulses |
| cfg_we_i | input | 1 | Load the four mode bits |
| cfg_aeoi_i | input | 1 | Automatic EOI enable |
| cfg_mode86_i | input | 1 | 1: two-pulse acknowledge, 0: three-pulse |
| cfg_rot_aeoi_i | input | 1 | Rotate on automatic EOI |
| cfg_smm_i | input | 1 | Special mask mode |
| eoi_we_i | input | 1 | Issue an EOI command this cycle |
| eoi_kind_i | input | 2 | 00 non-specific, 01 specific, 10 rotate non-specific, 11 no effect |
| eoi_lvl_i | input | 3 | Level for a specific EOI |
| imr_we_i | input | 1 | Load the mask register |
| imr_i | input | 8 | Mask value, 1 masks the level |
| vec_o | output | 3 | Latched vector index |
| vec_valid_o | output | 1 | Vector index valid during the last pulse |

## Verification
All 256 request patterns are swept twice: once with no mask and once with a mask derived from each pattern. For every pattern the bench checks that int_o matches the unmasked set, that the granted vector is the lowest unmasked level or the spurious 7, and that only strictly lower-numbered requests re-raise int_o while the level is in service. This separates mask errors, priority errors and blocking errors. Short hand-built sequences cover the rest: nested grants drive specific and reserved EOI codes, a masked in-service level under special mask mode shows whether a non-specific EOI skips it, and three-pulse trains check when the valid strobe appears. A sweep of the rotation pointer over all eight levels, with every line requesting, shows that the level after the one just rotated wins.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

    typedef enum logic [1:0] {
        ACK_IDLE = 2'd0,
        ACK_LOW  = 2'd1,
        ACK_GAP  = 2'd2
    } ack_state_e;

    typedef enum logic [1:0] {
        EOI_NONSPEC     = 2'b00,
        EOI_SPEC        = 2'b01,
        EOI_ROT_NONSPEC = 2'b10,
        EOI_RSVD        = 2'b11
    } eoi_kind_e;

endpackage

// File: rtl/irq_prio_pick.sv
// Rotating priority picker: the level just after ptr_i is most urgent.
// N must be a power of two so index arithmetic wraps by truncation.
module irq_prio_pick #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] vec_i,
    input  logic [W-1:0] ptr_i,
    output logic         found_o,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rank_o
);

    logic [W-1:0] idx;

    always_comb begin
        found_o = 1'b0;
        lvl_o   = '0;
        idx     = '0;
        for (int k = N - 1; k >= 0; k--) begin
            idx = ptr_i + W'(1) + W'(k);
            if (vec_i[idx]) begin
                found_o = 1'b1;
                lvl_o   = idx;
            end
        end
        rank_o = lvl_o - ptr_i - W'(1);
    end

endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_nest_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ack_n_i,
    input  logic       mode86_i,
    output ack_state_e st_o,
    output logic       first_fall_o,
    output logic       last_rise_o,
    output logic       vec_valid_o
);

    ack_state_e st_q, st_d;
    logic [1:0] cnt_q, cnt_d;
    logic       ack_n_q;
    logic       fall, rise, at_last;
    logic [1:0] last_idx;

    assign fall     = ack_n_q & ~ack_n_i;
    assign rise     = ~ack_n_q & ack_n_i;
    assign last_idx = mode86_i ? 2'd1 : 2'd2;
    assign at_last  = (cnt_q >= last_idx);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ACK_IDLE;
            cnt_q   <= 2'd0;
            ack_n_q <= 1'b1;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            ack_n_q <= ack_n_i;
        end
    end

    // Next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ACK_IDLE: begin
                if (fall) begin
                    st_d  = ACK_LOW;
                    cnt_d = 2'd0;
                end
            end
            ACK_LOW: begin
                if (rise) begin
                    if (at_last) begin
                        st_d = ACK_IDLE;
                    end else begin
                        st_d  = ACK_GAP;
                        cnt_d = cnt_q + 2'd1;
                    end
                end
            end
            ACK_GAP: begin
                if (fall) st_d = ACK_LOW;
            end
            default: st_d = ACK_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        st_o         = st_q;
        first_fall_o = (st_q == ACK_IDLE) && fall;
        last_rise_o  = (st_q == ACK_LOW) && rise && at_last;
        vec_valid_o  = (st_q == ACK_LOW) && at_last;
    end

    assert_first_fall_enters_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        first_fall_o |=> (st_q == ACK_LOW) && (cnt_q == 2'd0));

    assert_last_rise_returns_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        last_rise_o |=> (st_q == ACK_IDLE));

    assert_gap_only_after_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q == ACK_GAP) |-> $past(rise));

endmodule

// File: rtl/irq_service_regs.sv
module irq_service_regs #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en_i,
    input  logic [W-1:0] set_lvl_i,
    input  logic [N-1:0] clr_vec_i,
    input  logic         ptr_we_i,
    input  logic [W-1:0] ptr_nxt_i,
    output logic [N-1:0] isr_o,
    output logic [W-1:0] ptr_o
);

    logic [N-1:0] isr_q, set_vec;
    logic [W-1:0] ptr_q;

    always_comb begin
        set_vec = '0;
        if (set_en_i) set_vec[set_lvl_i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isr_q <= '0;
            ptr_q <= '1;
        end else begin
            isr_q <= (isr_q & ~clr_vec_i) | set_vec;
            if (ptr_we_i) ptr_q <= ptr_nxt_i;
        end
    end

    assign isr_o = isr_q;
    assign ptr_o = ptr_q;

    assert_single_isr_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(isr_q & ~$past(isr_q)) <= 1);

    assert_ptr_moves_only_on_rotate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_we_i |=> $stable(ptr_q));

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter  int NUM_LVL = 8,
    localparam int LVL_W   = $clog2(NUM_LVL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] req_i,
    output logic               int_o,
    input  logic               ack_n_i,
    input  logic               cfg_we_i,
    input  logic               cfg_aeoi_i,
    input  logic               cfg_mode86_i,
    input  logic               cfg_rot_aeoi_i,
    input  logic               cfg_smm_i,
    input  logic               eoi_we_i,
    input  logic [1:0]         eoi_kind_i,
    input  logic [LVL_W-1:0]   eoi_lvl_i,
    input  logic               imr_we_i,
    input  logic [NUM_LVL-1:0] imr_i,
    output logic [LVL_W-1:0]   vec_o,
    output logic               vec_valid_o
);

    localparam logic [LVL_W-1:0] SPUR_LVL = LVL_W'(NUM_LVL - 1);

    logic [NUM_LVL-1:0] irr_q, imr_q;
    logic               aeoi_q, mode86_q, rot_aeoi_q, smm_q;
    logic [LVL_W-1:0]   vec_q, serv_lvl_q;
    logic               serv_real_q;

    logic [NUM_LVL-1:0] isr_w, isr_blk, req_eff, clr_vec;
    logic [LVL_W-1:0]   ptr_w, ptr_nxt;
    logic               ptr_we;
    logic               req_found, isr_found, grant_ok;
    logic [LVL_W-1:0]   lvl_req, lvl_isr, rank_req, rank_isr;
    ack_state_e         ack_st;
    logic               first_fall, last_rise, vv;

    // Captured requests, mask and mode bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irr_q      <= '0;
            imr_q      <= '0;
            aeoi_q     <= 1'b0;
            mode86_q   <= 1'b0;
            rot_aeoi_q <= 1'b0;
            smm_q      <= 1'b0;
        end else begin
            irr_q <= req_i;
            if (imr_we_i) imr_q <= imr_i;
            if (cfg_we_i) begin
                aeoi_q     <= cfg_aeoi_i;
                mode86_q   <= cfg_mode86_i;
                rot_aeoi_q <= cfg_rot_aeoi_i;
                smm_q      <= cfg_smm_i;
            end
        end
    end

    assign req_eff = irr_q & ~imr_q;
    assign isr_blk = smm_q ? (isr_w & ~imr_q) : isr_w;

    irq_prio_pick #(.N(NUM_LVL), .W(LVL_W)) u_pick_req (
        .vec_i  (req_eff),
        .ptr_i  (ptr_w),
        .found_o(req_found),
        .lvl_o  (lvl_req),
        .rank_o (rank_req)
    );

    irq_prio_pick #(.N(NUM_LVL), .W(LVL_W)) u_pick_isr (
        .vec_i  (isr_blk),
        .ptr_i  (ptr_w),
        .found_o(isr_found),
        .lvl_o  (lvl_isr),
        .rank_o (rank_isr)
    );

    assign grant_ok = req_found && (!isr_found || (rank_req < rank_isr));

    irq_ack_fsm u_ack (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_n_i     (ack_n_i),
        .mode86_i    (mode86_q),
        .st_o        (ack_st),
        .first_fall_o(first_fall),
        .last_rise_o (last_rise),
        .vec_valid_o (vv)
    );

    // Vector and serviced-level latch at the first falling edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q       <= '0;
            serv_lvl_q  <= '0;
            serv_real_q <= 1'b0;
        end else if (first_fall) begin
            vec_q       <= grant_ok ? lvl_req : SPUR_LVL;
            serv_lvl_q  <= lvl_req;
            serv_real_q <= grant_ok;
        end
    end

    // End-of-interrupt resolution
    always_comb begin
        clr_vec = '0;
        ptr_we  = 1'b0;
        ptr_nxt = ptr_w;
        if (last_rise && aeoi_q && serv_real_q) begin
            clr_vec[serv_lvl_q] = 1'b1;
            if (rot_aeoi_q) begin
                ptr_we  = 1'b1;
                ptr_nxt = serv_lvl_q;
            end
        end
        if (eoi_we_i) begin
            unique case (eoi_kind_e'(eoi_kind_i))
                EOI_NONSPEC: begin
                    if (isr_found) clr_vec[lvl_isr] = 1'b1;
                end
                EOI_SPEC: begin
                    clr_vec[eoi_lvl_i] = 1'b1;
                end
                EOI_ROT_NONSPEC: begin
                    if (isr_found) begin
                        clr_vec[lvl_isr] = 1'b1;
                        ptr_we           = 1'b1;
                        ptr_nxt          = lvl_isr;
                    end
                end
                EOI_RSVD: begin
                end
                default: begin
                end
            endcase
        end
    end

    irq_service_regs #(.N(NUM_LVL), .W(LVL_W)) u_svc (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en_i (first_fall && grant_ok),
        .set_lvl_i(lvl_req),
        .clr_vec_i(clr_vec),
        .ptr_we_i (ptr_we),
        .ptr_nxt_i(ptr_nxt),
        .isr_o    (isr_w),
        .ptr_o    (ptr_w)
    );

    assign int_o       = grant_ok && (ack_st == ACK_IDLE);
    assign vec_o       = vec_q;
    assign vec_valid_o = vv;

    assert_int_needs_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> |(irr_q & ~imr_q));

    assert_int_not_same_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> !isr_blk[lvl_req]);

    assert_spec_eoi_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_we_i && eoi_kind_i == 2'b01 && !first_fall) |=> !isr_w[$past(eoi_lvl_i)]);

    assert_spurious_sets_nothing_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (first_fall && !grant_ok) |=> (vec_o == SPUR_LVL) && ($countones(isr_w & ~$past(isr_w)) == 0));

endmodule

// File: tb/sim_irq_nest_ctrl.sv
module sim_irq_nest_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] req;
    logic       int_o;
    logic       ack_n;
    logic       cfg_we, cfg_aeoi, cfg_m86, cfg_rot, cfg_smm;
    logic       eoi_we;
    logic [1:0] eoi_kind;
    logic [2:0] eoi_lvl;
    logic       imr_we;
    logic [7:0] imr;
    logic [2:0] vec_o;
    logic       vv;

    int n_chk  = 0;
    int n_fail = 0;
    bit m86    = 1'b0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    irq_nest_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .int_o(int_o), .ack_n_i(ack_n),
        .cfg_we_i(cfg_we), .cfg_aeoi_i(cfg_aeoi), .cfg_mode86_i(cfg_m86),
        .cfg_rot_aeoi_i(cfg_rot), .cfg_smm_i(cfg_smm),
        .eoi_we_i(eoi_we), .eoi_kind_i(eoi_kind), .eoi_lvl_i(eoi_lvl),
        .imr_we_i(imr_we), .imr_i(imr), .vec_o(vec_o), .vec_valid_o(vv)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int pick(input logic [7:0] v, input int p);
        for (int k = 0; k < 8; k++) begin
            int l = (p + 1 + k) % 8;
            if (v[l]) return l;
        end
        return 8;
    endfunction

    task automatic set_cfg(input bit a, input bit m, input bit r, input bit s);
        cfg_aeoi = a; cfg_m86 = m; cfg_rot = r; cfg_smm = s; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        m86 = m;
    endtask

    task automatic wr_imr(input logic [7:0] m);
        imr = m; imr_we = 1'b1;
        @(negedge clk);
        imr_we = 1'b0;
    endtask

    task automatic set_req(input logic [7:0] v);
        req = v;
        @(negedge clk);
    endtask

    task automatic do_eoi(input logic [1:0] k, input logic [2:0] l);
        eoi_kind = k; eoi_lvl = l; eoi_we = 1'b1;
        @(negedge clk);
        eoi_we = 1'b0;
    endtask

    task automatic do_ack(output int vec_seen);
        int np = m86 ? 2 : 3;
        vec_seen = -1;
        for (int p = 0; p < np; p++) begin
            ack_n = 1'b0;
            @(negedge clk);
            chk("R6 vec_valid per pulse", int'(vv), (p == np - 1) ? 1 : 0);
            if (p == np - 1) vec_seen = int'(vec_o);
            ack_n = 1'b1;
            @(negedge clk);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog all-requirements actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int vs;
        rst_n = 1'b0; req = '0; ack_n = 1'b1;
        cfg_we = 0; cfg_aeoi = 0; cfg_m86 = 0; cfg_rot = 0; cfg_smm = 0;
        eoi_we = 0; eoi_kind = 0; eoi_lvl = 0; imr_we = 0; imr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 int_o after reset", int'(int_o), 0);
        chk("R1 vec_valid after reset", int'(vv), 0);
        chk("R1 vec_o after reset", int'(vec_o), 0);

        set_cfg(0, 1, 0, 0);

        // Sweep every request pattern, without and with a mask
        for (int pass = 0; pass < 2; pass++) begin
            for (int v = 0; v < 256; v++) begin
                logic [7:0] m, eff;
                int e, hi;
                m = (pass == 1) ? 8'(v * 29 + 3) : 8'h00;
                wr_imr(m);
                set_req(8'(v));
                eff = 8'(v) & ~m;
                if (pass == 1) chk("R3 int_o with mask", int'(int_o), int'(eff != 0));
                else           chk("R2 int_o on request", int'(int_o), int'(eff != 0));
                do_ack(vs);
                e = pick(eff, 7);
                if (e == 8) chk("R12 spurious vector", vs, 7);
                else        chk("R5 granted vector", vs, e);
                hi = (e == 8) ? 0 : int'((eff & ((8'd1 << e) - 8'd1)) != 0);
                chk("R4 nesting blocks equal or lower", int'(int_o), hi);
                if (e != 8) begin
                    do_eoi(2'b00, 3'd0);
                    chk("R8 non-specific EOI", int'(int_o), int'(eff != 0));
                end
                set_req(8'h00);
            end
        end
        wr_imr(8'h00);

        // Spurious acknowledge leaves no in-service bit behind
        do_ack(vs);
        chk("R12 spurious vector", vs, 7);
        set_req(8'h80);
        chk("R12 no ISR after spurious", int'(int_o), 1);
        set_req(8'h00);

        // Three-pulse acknowledge
        set_cfg(0, 0, 0, 0);
        for (int i = 0; i < 3; i++) begin
            logic [7:0] v3;
            int e3;
            v3 = (i == 0) ? 8'h80 : (i == 1) ? 8'h24 : 8'h00;
            set_req(v3);
            do_ack(vs);
            e3 = pick(v3, 7);
            chk("R6 vector in 85 mode", vs, (e3 == 8) ? 7 : e3);
            if (e3 != 8) do_eoi(2'b00, 3'd0);
            set_req(8'h00);
        end
        set_cfg(0, 1, 0, 0);

        // Automatic EOI
        set_cfg(1, 1, 0, 0);
        set_req(8'h08);
        do_ack(vs);
        chk("R5 vector under AEOI", vs, 3);
        chk("R7 AEOI cleared ISR", int'(int_o), 1);
        set_req(8'h00);
        set_cfg(0, 1, 0, 0);

        // Nested grants, specific and reserved EOI
        set_req(8'h20);
        do_ack(vs);
        chk("R5 vector 5", vs, 5);
        set_req(8'h04);
        chk("R4 higher request passes", int'(int_o), 1);
        do_ack(vs);
        chk("R5 vector 2", vs, 2);
        set_req(8'h08);
        chk("R4 blocked by level 2", int'(int_o), 0);
        do_eoi(2'b11, 3'd2);
        chk("R9 reserved code no effect", int'(int_o), 0);
        do_eoi(2'b01, 3'd2);
        chk("R9 specific EOI level 2", int'(int_o), 1);
        do_ack(vs);
        chk("R5 vector 3", vs, 3);
        do_eoi(2'b01, 3'd5);
        chk("R9 specific EOI keeps level 3", int'(int_o), 0);
        set_req(8'h10);
        do_eoi(2'b00, 3'd0);
        chk("R8 non-specific clears level 3", int'(int_o), 1);
        set_req(8'h00);

        // Special mask mode
        set_cfg(0, 1, 0, 1);
        set_req(8'h04);
        do_ack(vs);
        chk("R5 vector 2 in SMM", vs, 2);
        wr_imr(8'h04);
        set_req(8'h20);
        chk("R10 masked ISR does not block", int'(int_o), 1);
        do_eoi(2'b00, 3'd0);
        set_cfg(0, 1, 0, 0);
        wr_imr(8'h00);
        chk("R10 NS EOI skipped masked ISR", int'(int_o), 0);
        do_eoi(2'b00, 3'd0);
        chk("R10 level 2 cleared later", int'(int_o), 1);
        set_req(8'h00);

        // Rotation by command over every level
        for (int l = 0; l < 8; l++) begin
            set_req(8'd1 << l);
            do_ack(vs);
            chk("R11 single request vector", vs, l);
            do_eoi(2'b10, 3'd0);
            set_req(8'hFF);
            do_ack(vs);
            chk("R11 rotated winner", vs, (l + 1) % 8);
            do_eoi(2'b00, 3'd0);
            set_req(8'h00);
        end

        // Rotation on automatic EOI
        set_cfg(1, 1, 1, 0);
        set_req(8'h10);
        do_ack(vs);
        chk("R11 AEOI rotate first grant", vs, 4);
        set_req(8'h00);
        set_req(8'hFF);
        do_ack(vs);
        chk("R11 AEOI rotated winner", vs, 5);
        set_req(8'h00);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule